// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which of six maskable interrupt sources a small CPU services next. Each source has a two-bit software level that software sets. Level 0 disables the source; levels 1 to 3 rank it. When two candidates share a software level, a fixed hardware order breaks the tie. Source index 0 (the top-level source) ranks highest and index 5 ranks lowest. The main program has the lowest rank of all.

The controller keeps the current CPU level and the rank of the context that is running. It grants a request when that request outranks the running context. The CPU can run in two modes. In concurrent mode a handler runs to completion before anything else is granted. In nested mode a handler can be preempted, and a seven-entry context stack restores the preempted level on each return strobe.

The controller also models the two sleep states. In WAIT, any enabled pending request wakes the CPU. In HALT, only sources flagged by the `HALT_WAKE_MASK` parameter can wake it. The first handler after leaving HALT is chosen among those flagged sources only, and that handler cannot be preempted by an unflagged source.

The controller is a state machine with five states:
- `ST_MAIN`: main program, empty stack.
- `ST_ISR`: one or more handlers active.
- `ST_WAIT`: sleeping in WAIT.
- `ST_HALT`: sleeping in HALT.
- `ST_HXG`: grant cycle after leaving HALT.

Its transitions are:
- MAIN→HALT on `halt_enter_i`.
- MAIN→WAIT on `wait_enter_i`.
- MAIN→ISR on a grant.
- ISR→MAIN when the last handler returns.
- WAIT→MAIN on wake.
- HALT→HXG on wake.
- HXG→ISR on a grant.
- HXG→MAIN when the request has vanished.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `grant_o` is 0, `cpu_lvl_o` is 0, `wake_o` is 0 and `ovf_o` is 0, and the controller is in the main program.
- R2: Among pending sources, the one with the highest software level is granted. Source i's level is `lvl_i[2*i+1:2*i]`. A source whose level is 0 is never granted and never wakes the CPU.
- R3: Among pending sources at equal software level, the one with the lowest index is granted.
- R4: A grant appears as a one-cycle pulse. In the cycle after the deciding clock edge, `grant_o` is one-hot and `grant_idx_o` holds the source index. In that same cycle, `cpu_lvl_o` equals the granted source's level.
- R5: In concurrent mode (`nest_en_i`=0), nothing is granted while a handler is active. A waiting request is granted in the clock cycle after the return strobe that empties the stack.
- R6: In nested mode (`nest_en_i`=1), a pending request preempts the running handler in either of two cases: its level is strictly higher, or its level is equal and its index is lower. An equal level with a higher index waits. A lower level also waits.
- R7: While `cpu_lvl_o` is 3, no request is granted, whatever its level or index.
- R8: Each return strobe (`iret_i`) restores the level of the context that was preempted. A return strobe in the main program is ignored.
- R9: In WAIT, `wake_o` pulses for one cycle when any enabled request is pending. The best request is granted on the following edge.
- R10: In HALT, only sources flagged in `HALT_WAKE_MASK` (default: sources 0 and 2) wake the CPU. Unflagged requests leave `wake_o` and `grant_o` at 0.
- R11: After HALT, the first grant goes to the best flagged source, even if an unflagged source has a higher level. The unflagged source is granted only after that first handler returns.
- R12: The stack holds 7 saved contexts. A preemption that would exceed this is blocked, and this sets the sticky `ovf_o` flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Pending request per source |
| lvl_i | input | 12 | Two-bit software level per source; source i uses bits 2i+1:2i |
| nest_en_i | input | 1 | 1 = nested mode, 0 = concurrent mode |
| iret_i | input | 1 | Handler return strobe |
| wait_enter_i | input | 1 | CPU enters WAIT (accepted in main program) |
| halt_enter_i | input | 1 | CPU enters HALT (accepted in main program) |
| grant_o | output | 6 | One-hot grant pulse |
| grant_idx_o | output | 3 | Index of the last granted source |
| cpu_lvl_o | output | 2 | Current CPU software level |
| wake_o | output | 1 | Wake-up pulse out of WAIT or HALT |
| ovf_o | output | 1 | Sticky flag: nesting blocked by a full stack |

## Verification
A table of request and level patterns covers the arbitration rule:
- A single request checks the basic grant.
- A level contest checks that the software level dominates the hardware order.
- Equal-level ties check that the fixed order decides.
- Disabled sources check that level 0 removes a source.
- A fully loaded vector checks the whole rule at once.

Directed sequences then separate the two servicing modes. Concurrent mode must hold an outranking request until the return strobe. Nested mode must preempt on a strictly higher level or a better tie, and must hold a worse tie or a lower level. The remaining sequences cover the level-3 mask, WAIT and HALT wake gating, the flagged-first grant after HALT, and the blocked eighth nesting that raises `ovf_o`.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int LVL_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    // CPU level that masks every maskable source
    localparam lvl_t LVL_MASKED = 2'd3;

    typedef enum logic [2:0] {
        ST_MAIN = 3'd0,
        ST_ISR  = 3'd1,
        ST_WAIT = 3'd2,
        ST_HALT = 3'd3,
        ST_HXG  = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/irq_pick.sv
// Two-level arbiter: software level first, then fixed index order
// (lower index wins). Also reports whether the winner outranks the
// running context.
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]       req_i,
    input  logic [N_SRC-1:0]       cand_mask_i,
    input  logic [LVL_W*N_SRC-1:0] lvl_i,
    input  lvl_t                   cur_lvl_i,
    input  logic [IDX_W-1:0]       cur_idx_i,
    output logic                   win_vld_o,
    output logic [IDX_W-1:0]       win_idx_o,
    output lvl_t                   win_lvl_o,
    output logic                   beats_o
);

    lvl_t             src_lvl [N_SRC];
    logic [N_SRC-1:0] live;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_lvl[g] = lvl_i[LVL_W*g +: LVL_W];
        assign live[g]    = req_i[g] & cand_mask_i[g] & (src_lvl[g] != '0);
    end

    // Scan from lowest rank to highest; ">=" lets a lower index take ties.
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i] && (!win_vld_o || src_lvl[i] >= win_lvl_o)) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = src_lvl[i];
            end
        end
    end

    always_comb begin
        beats_o = win_vld_o
               && (cur_lvl_i != LVL_MASKED)
               && ((win_lvl_o > cur_lvl_i)
                   || ((win_lvl_o == cur_lvl_i) && (win_idx_o < cur_idx_i)));
    end

endmodule

// File: rtl/irq_ctx_stack.sv
// LIFO of preempted contexts (level + rank).
module irq_ctx_stack #(
    parameter int DEPTH = 7,
    parameter int W     = 5,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     dout_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] top_ptr;

    assign wr_ptr  = PTR_W'(count_q);
    assign top_ptr = PTR_W'(count_q - 1'b1);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    assign count_o = count_q;
    assign dout_o  = empty_o ? '0 : mem[top_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push_i && !full_o) begin
            count_q <= count_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            mem[wr_ptr] <= din_i;
        end
    end

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o));

    p_pop_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && empty_o));

    p_depth_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int               N_SRC          = 6,
    parameter int               STACK_DEPTH    = 7,
    parameter logic [N_SRC-1:0] HALT_WAKE_MASK = 6'b000101,
    parameter int               IDX_W          = $clog2(N_SRC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req_i,
    input  logic [LVL_W*N_SRC-1:0] lvl_i,
    input  logic                   nest_en_i,
    input  logic                   iret_i,
    input  logic                   wait_enter_i,
    input  logic                   halt_enter_i,
    output logic [N_SRC-1:0]       grant_o,
    output logic [IDX_W-1:0]       grant_idx_o,
    output logic [LVL_W-1:0]       cpu_lvl_o,
    output logic                   wake_o,
    output logic                   ovf_o
);

    localparam int               CTX_W    = LVL_W + IDX_W;
    localparam int               CNT_W    = $clog2(STACK_DEPTH + 1);
    localparam logic [IDX_W-1:0] MAIN_IDX = IDX_W'(N_SRC);

    typedef struct packed {
        lvl_t             lvl;
        logic [IDX_W-1:0] idx;
    } ctx_t;

    localparam ctx_t MAIN_CTX = '{lvl: '0, idx: MAIN_IDX};

    ctl_state_e state_q, state_d;
    ctx_t       cur_q, cur_d;
    logic       hx_q, hx_d;
    logic       ovf_q, ovf_d;

    logic [N_SRC-1:0] grant_q;
    logic [IDX_W-1:0] gidx_q;
    logic             wake_q;

    // ---------------- request qualification ----------------
    logic [N_SRC-1:0] lvl_nz;
    for (genvar g = 0; g < N_SRC; g++) begin : g_nz
        assign lvl_nz[g] = |lvl_i[LVL_W*g +: LVL_W];
    end

    logic any_en, any_halt;
    assign any_en   = |(req_i & lvl_nz);
    assign any_halt = |(req_i & lvl_nz & HALT_WAKE_MASK);

    logic [N_SRC-1:0] cand_mask;
    assign cand_mask = ((state_q == ST_HXG) || hx_q) ? HALT_WAKE_MASK : {N_SRC{1'b1}};

    // ---------------- arbiter ----------------
    logic             win_vld, beats;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;

    irq_pick #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i       (req_i),
        .cand_mask_i (cand_mask),
        .lvl_i       (lvl_i),
        .cur_lvl_i   (cur_q.lvl),
        .cur_idx_i   (cur_q.idx),
        .win_vld_o   (win_vld),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl),
        .beats_o     (beats)
    );

    // ---------------- context stack ----------------
    logic             take, pop;
    logic [CTX_W-1:0] stk_dout;
    logic [CNT_W-1:0] stk_cnt;
    logic             stk_full, stk_empty;

    irq_ctx_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (CTX_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (take),
        .pop_i   (pop),
        .din_i   (cur_q),
        .dout_o  (stk_dout),
        .count_o (stk_cnt),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    logic last_ret;
    assign last_ret = pop && (stk_cnt == CNT_W'(1));

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        pop     = 1'b0;
        ovf_d   = ovf_q;
        unique case (state_q)
            ST_MAIN: begin
                if (halt_enter_i) begin
                    state_d = ST_HALT;
                end else if (wait_enter_i) begin
                    state_d = ST_WAIT;
                end else if (beats) begin
                    take    = 1'b1;
                    state_d = ST_ISR;
                end
            end
            ST_ISR: begin
                if (iret_i && !stk_empty) begin
                    pop = 1'b1;
                    if (stk_cnt == CNT_W'(1)) begin
                        state_d = ST_MAIN;
                    end
                end else if (nest_en_i && beats) begin
                    if (stk_full) begin
                        ovf_d = 1'b1;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (any_en) begin
                    state_d = ST_MAIN;
                end
            end
            ST_HALT: begin
                if (any_halt) begin
                    state_d = ST_HXG;
                end
            end
            ST_HXG: begin
                if (beats) begin
                    take    = 1'b1;
                    state_d = ST_ISR;
                end else begin
                    state_d = ST_MAIN;
                end
            end
            default: state_d = ST_MAIN;
        endcase
    end

    always_comb begin
        cur_d = cur_q;
        hx_d  = hx_q;
        if (take) begin
            cur_d = '{lvl: win_lvl, idx: win_idx};
        end else if (pop) begin
            cur_d = ctx_t'(stk_dout);
        end
        if (take && (state_q == ST_HXG)) begin
            hx_d = 1'b1;
        end else if (last_ret) begin
            hx_d = 1'b0;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MAIN;
            cur_q   <= MAIN_CTX;
            hx_q    <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            hx_q    <= hx_d;
            ovf_q   <= ovf_d;
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            gidx_q  <= '0;
            wake_q  <= 1'b0;
        end else begin
            grant_q <= take ? (N_SRC'(1) << win_idx) : '0;
            if (take) begin
                gidx_q <= win_idx;
            end
            wake_q <= ((state_q == ST_WAIT) && any_en)
                   || ((state_q == ST_HALT) && any_halt);
        end
    end

    assign grant_o     = grant_q;
    assign grant_idx_o = gidx_q;
    assign cpu_lvl_o   = cur_q.lvl;
    assign wake_o      = wake_q;
    assign ovf_o       = ovf_q;

    // ---------------- assertions ----------------
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> (cpu_lvl_o != '0));

    p_conc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISR && !nest_en_i) |=> (grant_o == '0));

    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_lvl_o == LVL_MASKED) |=> (grant_o == '0));

    p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> ($past(state_q) == ST_WAIT || $past(state_q) == ST_HALT));

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (grant_o == '0));

    p_halt_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HXG) |=> ((grant_o & ~HALT_WAKE_MASK) == '0));

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;

    localparam int N     = 6;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     req;
    logic [2*N-1:0]   lvl;
    logic             nest_en, iret, wait_en, halt_en;
    logic [N-1:0]     grant;
    logic [IDX_W-1:0] gidx;
    logic [1:0]       cpu_lvl;
    logic             wake, ovf;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    irq_nest_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .lvl_i        (lvl),
        .nest_en_i    (nest_en),
        .iret_i       (iret),
        .wait_enter_i (wait_en),
        .halt_enter_i (halt_en),
        .grant_o      (grant),
        .grant_idx_o  (gidx),
        .cpu_lvl_o    (cpu_lvl),
        .wake_o       (wake),
        .ovf_o        (ovf)
    );

    // {req, levels s5..s0, expected one-hot grant, expected cpu level}
    localparam logic [25:0] VEC [9] = '{
        {6'b000001, 12'b01_01_01_01_01_01, 6'b000001, 2'd1},
        {6'b100000, 12'b10_01_01_01_01_01, 6'b100000, 2'd2},
        {6'b100001, 12'b10_01_01_01_01_01, 6'b100000, 2'd2},
        {6'b100001, 12'b01_01_01_01_01_01, 6'b000001, 2'd1},
        {6'b010100, 12'b01_11_01_11_01_01, 6'b000100, 2'd3},
        {6'b000110, 12'b01_01_01_01_00_01, 6'b000100, 2'd1},
        {6'b000011, 12'b01_01_01_01_00_00, 6'b000000, 2'd0},
        {6'b111111, 12'b10_10_11_10_10_10, 6'b001000, 2'd3},
        {6'b011000, 12'b01_10_10_01_01_01, 6'b001000, 2'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_iret;
        iret = 1'b1;
        tick();
        iret = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input logic [1:0] v);
        lvl[2*idx +: 2] = v;
    endtask

    task automatic pulse_req(input int idx);
        req[idx] = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; lvl = '0; nest_en = 1'b0;
        iret = 1'b0; wait_en = 1'b0; halt_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 grant", grant, 0);
        chk("R1 cpu_lvl", cpu_lvl, 0);
        chk("R1 wake", wake, 0);
        chk("R1 ovf", ovf, 0);

        // R2 R3 R4 table walk in concurrent mode
        for (int v = 0; v < 9; v++) begin
            int exp_idx;
            exp_idx = 0;
            for (int b = 0; b < N; b++) if (VEC[v][2+b]) exp_idx = b;
            lvl = VEC[v][19:8];
            req = VEC[v][25:20];
            tick();
            chk($sformatf("R2/R3 vec%0d grant", v), grant, VEC[v][7:2]);
            chk($sformatf("R4 vec%0d level", v), cpu_lvl, VEC[v][1:0]);
            req = '0;
            if (VEC[v][7:2] != '0) begin
                chk($sformatf("R4 vec%0d index", v), gidx, exp_idx);
                tick();
                chk($sformatf("R4 vec%0d pulse end", v), grant, 0);
                do_iret();
                chk($sformatf("R8 vec%0d return", v), cpu_lvl, 0);
            end
        end

        // R5 concurrent mode holds an outranking request
        nest_en = 1'b0;
        lvl = 12'b01_01_01_01_01_01;
        pulse_req(5);
        chk("R5 first grant", grant, 6'b100000);
        req = '0;
        req[0] = 1'b1;
        tick();
        chk("R5 held a", grant, 0);
        tick();
        chk("R5 held b", grant, 0);
        do_iret();
        chk("R5 no grant on return edge", grant, 0);
        tick();
        chk("R5 granted after return", grant, 6'b000001);
        req = '0;
        do_iret();

        // R6 R8 nested preemption
        nest_en = 1'b1;
        lvl = 12'b01_01_01_10_01_01;
        pulse_req(3);
        chk("R6 base grant", grant, 6'b001000);
        req = '0;
        pulse_req(5);
        chk("R6 equal level lower rank waits", grant, 0);
        req = '0;
        pulse_req(1);
        chk("R6 equal level higher rank preempts", grant, 6'b000010);
        req = '0;
        pulse_req(2);
        chk("R6 higher level preempts", grant, 6'b000100);
        chk("R6 level raised", cpu_lvl, 2);
        req = '0;
        pulse_req(0);
        chk("R6 lower level waits", grant, 0);
        req = '0;
        do_iret();
        chk("R8 restore 1", cpu_lvl, 1);
        do_iret();
        chk("R8 restore 2", cpu_lvl, 1);
        do_iret();
        chk("R8 restore main", cpu_lvl, 0);
        do_iret();
        chk("R8 extra return ignored lvl", cpu_lvl, 0);
        pulse_req(0);
        chk("R8 extra return ignored grant", grant, 6'b000001);
        req = '0;
        do_iret();

        // R7 level 3 masks everything
        lvl = 12'b01_11_01_01_01_11;
        pulse_req(4);
        chk("R7 level3 grant", cpu_lvl, 3);
        req = '0;
        pulse_req(0);
        chk("R7 masked", grant, 0);
        req = '0;
        do_iret();
        chk("R7 return", cpu_lvl, 0);

        // R9 WAIT wake
        nest_en = 1'b0;
        lvl = 12'b01_01_01_01_00_01;
        wait_en = 1'b1;
        tick();
        wait_en = 1'b0;
        req[1] = 1'b1;
        tick();
        chk("R9 disabled no wake", wake, 0);
        chk("R2 disabled no grant", grant, 0);
        set_lvl(1, 2'b01);
        tick();
        chk("R9 wake", wake, 1);
        chk("R9 no grant at wake", grant, 0);
        tick();
        chk("R9 grant after wake", grant, 6'b000010);
        chk("R9 wake pulse ends", wake, 0);
        req = '0;
        do_iret();

        // R10 R11 HALT
        nest_en = 1'b1;
        lvl = 12'b01_01_01_01_10_01;
        halt_en = 1'b1;
        tick();
        halt_en = 1'b0;
        req[1] = 1'b1;
        tick();
        chk("R10 unflagged no wake", wake, 0);
        chk("R10 unflagged no grant", grant, 0);
        req[2] = 1'b1;
        tick();
        chk("R10 flagged wake", wake, 1);
        tick();
        chk("R11 flagged granted first", grant, 6'b000100);
        chk("R11 level", cpu_lvl, 1);
        req[2] = 1'b0;
        tick();
        chk("R11 no preempt by unflagged", grant, 0);
        do_iret();
        chk("R11 return", cpu_lvl, 0);
        tick();
        chk("R11 unflagged after", grant, 6'b000010);
        chk("R11 unflagged level", cpu_lvl, 2);
        req = '0;
        do_iret();

        // R12 stack limit
        nest_en = 1'b1;
        lvl = 12'b01_01_01_01_01_01;
        for (int s = 5; s >= 0; s--) begin
            pulse_req(s);
            chk($sformatf("R12 nest src%0d", s), grant, 1 << s);
            req = '0;
        end
        set_lvl(5, 2'b10);
        pulse_req(5);
        chk("R12 seventh grant", grant, 6'b100000);
        chk("R12 no ovf yet", ovf, 0);
        req = '0;
        set_lvl(4, 2'b11);
        pulse_req(4);
        chk("R12 blocked", grant, 0);
        chk("R12 ovf set", ovf, 1);
        chk("R12 level kept", cpu_lvl, 2);
        req = '0;
        for (int k = 0; k < 7; k++) do_iret();
        chk("R12 unwound", cpu_lvl, 0);
        chk("R12 ovf sticky", ovf, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule